// File: doc/BRIEF.md
# Programmable-Timing External Pattern Memory Controller

This block is the master side of an asynchronous parallel memory port for NOR flash, mask ROM, SRAM or parts with matching timing. An internal requester hands it single 32-bit read or write requests over a valid/ready handshake. The block turns each request into a sequence on the pins: a halfword address, an active-low output enable, an active-low write strobe and a data bus with separate in, out and drive-enable lines toward the pad ring. Reads return their data with a one-cycle valid pulse.

Three clock counts set the access timing, all in system clocks. The float count F is the field value plus one, with a 2-bit field. It is the quiet time after an address change before any strobe asserts. The random count R is the field value plus one, with a 4-bit field. It is the strobe time of a full access. The page count P is the field value plus one, with a 3-bit field. It is the time of a read that stays inside the open page. The bus can run 32 bits wide, or 16 bits wide with every request split into two beats. The address and output enable keep their last values between accesses.

An active-low float request from outside releases all driven pins while it is low, and the access sequence stalls for those cycles.

Top module: `ext_mem_ctrl`

## Requirements
- R1: After reset, `req_ready_o`=1 (with `mem_hiz_ni` high), `mem_oe_no`=1, `mem_we_no`=1, `mem_dq_en_o`=0, `rsp_valid_o`=0 and `mem_addr_o`=0.
- R2: A random read puts its address on the pins at the accept edge. It holds `mem_oe_no` high for F clocks and low for the next R clocks. It samples `mem_dq_i` at the end of those R clocks, F+R clocks after the accept edge. `rsp_valid_o` is high for exactly one cycle, right after the sample edge, with the data on `rsp_rdata_o`.
- R3: A read beat whose page tag matches the previous beat, when that previous beat was a read, takes P clocks. The output enable stays low throughout. The page tag is the halfword address shifted right by log2(PAGE_WORDS)+1 on the 32-bit bus, or by log2(PAGE_WORDS) on the 16-bit bus.
- R4: A read to another page, the first read after reset and the first read after a write all take a full F+R random cycle.
- R5: A write beat waits F clocks and then drives `mem_we_no` low for exactly R clocks. `mem_dq_en_o` is high while the strobe is low and for one more clock after it rises, and low after that. A write beat lasts F+R+1 clocks.
- R6: With `cfg_wide_i`=0, each request becomes two beats on `mem_dq_*[15:0]`. The first beat uses halfword address {word,0} and carries bits 15:0. The second uses {word,1} and carries bits 31:16. A read returns both halves in one response after the second beat.
- R7: With `cfg_wide_i`=1, a request to word address w drives halfword address {w,0}, and all 32 data lines carry the word.
- R8: After an access ends, `mem_addr_o` holds the last beat's address until the next accept. `mem_oe_no` stays low after a read and high after a write.
- R9: While `mem_hiz_ni` is low, `mem_ctl_en_o`=0, `mem_dq_en_o`=0 and `req_ready_o`=0. Each clock edge that samples it low delays the access by one clock and changes nothing else.
- R10: `req_ready_o` is high only when no access is in progress, so only one request is outstanding at a time.
- R11: `mem_oe_no` and `mem_we_no` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_float_i | input | 2 | Float clocks minus one |
| cfg_rand_i | input | 4 | Random-access clocks minus one |
| cfg_page_i | input | 3 | Page-access clocks minus one |
| cfg_wide_i | input | 1 | 1: 32-bit bus, 0: 16-bit bus |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_we_i | input | 1 | 1 for write |
| req_addr_i | input | MA_W-1 | 32-bit word address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | DATA_W | Read data |
| mem_hiz_ni | input | 1 | External float request, active low |
| mem_addr_o | output | MA_W | Halfword address to the memory |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_ctl_en_o | output | 1 | Pad drive enable for address and strobes |
| mem_dq_o | output | DATA_W | Write data toward the pads |
| mem_dq_en_o | output | 1 | Pad drive enable for data |
| mem_dq_i | input | DATA_W | Read data from the pads |

## Verification
The bench builds the block with PAGE_WORDS=4 and keeps MA_W=25 and DATA_W=32. Small pages let short random address ranges cross page boundaries often, so page hits and page misses both occur in large numbers. The timing fields are redrawn between request groups over their whole range, including the one-clock minimum of each count. Bus mode changes at the same points, and float requests are injected in the middle of reads, so stalls and two-beat splits are mixed with every timing setting.

// File: rtl/emc_pkg.sv
package emc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLOAT,
    ST_STROBE,
    ST_PAGE,
    ST_TAIL
  } emc_state_e;
endpackage

// File: rtl/emc_phase_timer.sv
module emc_phase_timer
  import emc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             launch_i,
  input  logic             page_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] float_len_i,
  input  logic [CNT_W-1:0] rand_len_i,
  input  logic [CNT_W-1:0] page_len_i,
  output emc_state_e       state_o,
  output logic             done_o
);
  emc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last    = (cnt_q == '0);
  assign state_o = state_q;
  assign done_o  = run_i && ((state_q == ST_STROBE && last && !wr_i) ||
                             (state_q == ST_PAGE && last) ||
                             (state_q == ST_TAIL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (run_i) begin
      if (launch_i) begin
        state_q <= page_i ? ST_PAGE : ST_FLOAT;
        cnt_q   <= page_i ? page_len_i : float_len_i;
      end else begin
        unique case (state_q)
          ST_FLOAT: begin
            if (last) begin
              state_q <= ST_STROBE;
              cnt_q   <= rand_len_i;
            end else cnt_q <= cnt_q - 1'b1;
          end
          ST_STROBE: begin
            if (last) state_q <= wr_i ? ST_TAIL : ST_IDLE;
            else cnt_q <= cnt_q - 1'b1;
          end
          ST_PAGE: begin
            if (last) state_q <= ST_IDLE;
            else cnt_q <= cnt_q - 1'b1;
          end
          ST_TAIL: state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R5 R2
  strobe_after_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && $past(state_q) != ST_STROBE) |-> $past(state_q) == ST_FLOAT);

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(state_q) && $stable(cnt_q));
endmodule

// File: rtl/emc_page_cmp.sv
module emc_page_cmp #(
  parameter int MA_W       = 25,
  parameter int PAGE_WORDS = 8
) (
  input  logic [MA_W-1:0] a_i,
  input  logic [MA_W-1:0] b_i,
  input  logic            wide_i,
  output logic            same_o
);
  localparam int PGB = $clog2(PAGE_WORDS);

  logic [MA_W-1:0] tag_a, tag_b;

  always_comb begin
    if (wide_i) begin
      tag_a = a_i >> (PGB + 1);
      tag_b = b_i >> (PGB + 1);
    end else begin
      tag_a = a_i >> PGB;
      tag_b = b_i >> PGB;
    end
    same_o = (tag_a == tag_b);
  end
endmodule

// File: rtl/emc_lane.sv
module emc_lane #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              hi_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HW = DATA_W / 2;

  logic [DATA_W-1:0] rbuf_q;

  assign rdata_o = rbuf_q;

  always_comb begin
    if (wide_i) dq_o = wdata_i;
    else        dq_o = {{HW{1'b0}}, hi_i ? wdata_i[DATA_W-1:HW] : wdata_i[HW-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rbuf_q <= '0;
    else if (cap_i) begin
      if (wide_i)    rbuf_q <= dq_i;
      else if (hi_i) rbuf_q[DATA_W-1:HW] <= dq_i[HW-1:0];
      else           rbuf_q[HW-1:0] <= dq_i[HW-1:0];
    end
  end
endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
  import emc_pkg::*;
#(
  parameter int MA_W       = 25,
  parameter int DATA_W     = 32,
  parameter int PAGE_WORDS = 8,
  parameter int FLT_W      = 2,
  parameter int RND_W      = 4,
  parameter int PAG_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLT_W-1:0]  cfg_float_i,
  input  logic [RND_W-1:0]  cfg_rand_i,
  input  logic [PAG_W-1:0]  cfg_page_i,
  input  logic              cfg_wide_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [MA_W-2:0]   req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              mem_hiz_ni,
  output logic [MA_W-1:0]   mem_addr_o,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_ctl_en_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_en_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int AW    = MA_W - 1;
  localparam int CNT_W = (RND_W > FLT_W) ? ((RND_W > PAG_W) ? RND_W : PAG_W)
                                         : ((FLT_W > PAG_W) ? FLT_W : PAG_W);

  emc_state_e        state;
  logic              done, accept, more, launch, new_we, open_rd, same, page_go;
  logic              wr_q, hi_q, last_rd_q, rsp_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [MA_W-1:0]   ha_q, next_ha;

  assign req_ready_o = mem_hiz_ni && (state == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign more        = done && !cfg_wide_i && !hi_q;
  assign launch      = accept || more;
  assign next_ha     = accept ? {req_addr_i, 1'b0} : {addr_q, 1'b1};
  assign new_we      = accept ? req_we_i : wr_q;
  // an open read page exists after a completed read beat
  assign open_rd     = accept ? last_rd_q : !wr_q;
  assign page_go     = !new_we && open_rd && same;

  emc_page_cmp #(.MA_W(MA_W), .PAGE_WORDS(PAGE_WORDS)) i_page_cmp (
    .a_i    (next_ha),
    .b_i    (ha_q),
    .wide_i (cfg_wide_i),
    .same_o (same)
  );

  emc_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (mem_hiz_ni),
    .launch_i    (launch),
    .page_i      (page_go),
    .wr_i        (wr_q),
    .float_len_i (CNT_W'(cfg_float_i)),
    .rand_len_i  (CNT_W'(cfg_rand_i)),
    .page_len_i  (CNT_W'(cfg_page_i)),
    .state_o     (state),
    .done_o      (done)
  );

  emc_lane #(.DATA_W(DATA_W)) i_lane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wide_i  (cfg_wide_i),
    .hi_i    (hi_q),
    .cap_i   (done && !wr_q),
    .dq_i    (mem_dq_i),
    .wdata_i (wdata_q),
    .dq_o    (mem_dq_o),
    .rdata_o (rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      hi_q      <= 1'b0;
      last_rd_q <= 1'b0;
      rsp_q     <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      ha_q      <= '0;
    end else begin
      rsp_q <= done && !wr_q && !more;
      if (launch) ha_q <= next_ha;
      if (accept) begin
        wr_q    <= req_we_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        hi_q    <= 1'b0;
      end else if (more) begin
        hi_q <= 1'b1;
      end
      if (launch && new_we)    last_rd_q <= 1'b0;
      else if (done && !wr_q)  last_rd_q <= 1'b1;
    end
  end

  assign rsp_valid_o  = rsp_q;
  assign mem_addr_o   = ha_q;
  assign mem_ctl_en_o = mem_hiz_ni;
  assign mem_we_no    = !(state == ST_STROBE && wr_q);
  assign mem_oe_no    = !((state == ST_STROBE && !wr_q) || state == ST_PAGE ||
                          (state == ST_IDLE && last_rd_q));
  assign mem_dq_en_o  = mem_hiz_ni && wr_q && (state == ST_STROBE || state == ST_TAIL);

  // R11
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  // R2
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R9
  hiz_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_hiz_ni |=> !rsp_valid_o);

  // R5
  wr_tail_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_we_no) && mem_hiz_ni) |-> mem_dq_en_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_valid_i) |=> $stable(mem_addr_o) && $stable(mem_oe_no));

  // R10
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_we_no && !mem_dq_en_o));
endmodule

// File: tb/test_ext_mem_ctrl.sv
module test_ext_mem_ctrl;
  localparam int MA_W = 25;
  localparam int DW   = 32;
  localparam int PW   = 4;
  localparam int PGB  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_f = 2'd1;
  logic [3:0] cfg_r = 4'd2;
  logic [2:0] cfg_p = 3'd1;
  logic cfg_wide = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0, hiz_n = 1'b1;
  logic [MA_W-2:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, oe_n, we_n, ctl_en, dq_en;
  logic [DW-1:0] rsp_rdata, dq_o, dq_i;
  logic [MA_W-1:0] maddr;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, ev_total = 0, wlow = 0, tail_bad = 0;
  logic [MA_W-1:0] ev_a [4];
  logic [DW-1:0]   ev_d [4];
  int ev_l [4], ev_c [4];
  bit prev_rd = 1'b0;
  logic [MA_W-1:0] prev_ha = '0;

  always #5 clk = ~clk;

  ext_mem_ctrl #(.MA_W(MA_W), .DATA_W(DW), .PAGE_WORDS(PW)) i_ext_mem_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_float_i(cfg_f), .cfg_rand_i(cfg_r), .cfg_page_i(cfg_p), .cfg_wide_i(cfg_wide),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_hiz_ni(hiz_n), .mem_addr_o(maddr), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_ctl_en_o(ctl_en), .mem_dq_o(dq_o), .mem_dq_en_o(dq_en), .mem_dq_i(dq_i)
  );

  function automatic logic [15:0] hw(input logic [MA_W-1:0] ha);
    hw = ha[15:0] * 16'h9E37 ^ {ha[24:16], 7'h5A} ^ 16'h1234;
  endfunction

  function automatic logic [DW-1:0] exp_word(input logic [MA_W-2:0] w);
    exp_word = {hw({w, 1'b1}), hw({w, 1'b0})};
  endfunction

  function automatic bit same_pg(input logic [MA_W-1:0] a, input logic [MA_W-1:0] b,
                                 input bit wide);
    same_pg = wide ? ((a >> (PGB + 1)) == (b >> (PGB + 1))) : ((a >> PGB) == (b >> PGB));
  endfunction

  // memory model: data valid only while output enable is low
  always_comb begin
    if (!oe_n && ctl_en)
      dq_i = cfg_wide ? {hw(maddr | 25'd1), hw(maddr)} : {16'hDEAD, hw(maddr)};
    else
      dq_i = 32'hBAD0_BAD0;
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && ctl_en) begin
      if (!we_n) begin
        if (wlow == 0) ev_c[ev_total % 4] = cyc;
        wlow++;
        ev_a[ev_total % 4] = maddr;
        ev_d[ev_total % 4] = dq_o;
        if (!dq_en) tail_bad++;
      end else if (wlow > 0) begin
        ev_l[ev_total % 4] = wlow;
        if (!dq_en) tail_bad++;
        ev_total++;
        wlow = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [MA_W-2:0] w, input logic [DW-1:0] wd,
                        input int stall_at, input int stall_len);
    int F, R, P, exp_l, n, s, ev0, tb0, acc_cyc, guard;
    logic [MA_W-1:0] ha0, ha1, last_ha;
    bit wide;
    wide = cfg_wide;
    F = int'(cfg_f) + 1; R = int'(cfg_r) + 1; P = int'(cfg_p) + 1;
    ha0 = {w, 1'b0}; ha1 = {w, 1'b1};
    if (we) begin
      exp_l = (wide ? 1 : 2) * (F + R + 1);
      prev_rd = 1'b0;
      last_ha = wide ? ha0 : ha1;
    end else begin
      exp_l = (prev_rd && same_pg(ha0, prev_ha, wide)) ? P : F + R;
      if (!wide) exp_l += same_pg(ha1, ha0, wide) ? P : F + R;
      prev_rd = 1'b1;
      last_ha = wide ? ha0 : ha1;
    end
    prev_ha = last_ha;
    exp_l += stall_len;
    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_we = we; req_addr = w; req_wdata = wd;
    ev0 = ev_total; tb0 = tail_bad;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc_cyc = cyc;
    n = 0; s = 0;
    while (n < 400) begin
      if (n == stall_at && stall_len > 0 && s == 0) hiz_n = 1'b0;
      @(posedge clk); n++;
      @(negedge clk);
      if (!hiz_n) begin
        // R9 pins released and handshake closed while floated
        chk(!ctl_en && !dq_en && !req_ready, "R9 float release", {ctl_en, dq_en, req_ready}, 0);
        s++;
        if (s == stall_len) hiz_n = 1'b1;
      end
      if (!we && rsp_valid) break;
      if (we && req_ready) break;
    end
    chk(n == exp_l, we ? "R5 write duration" : (wide ? "R2/R3/R4 read latency" : "R6 split read latency"),
        n, exp_l);
    if (!we) begin
      chk(rsp_rdata == exp_word(w), wide ? "R2 R7 read data" : "R6 read data order",
          rsp_rdata, exp_word(w));
      @(negedge clk);
      chk(!rsp_valid, "R2 pulse width", rsp_valid, 0);
    end else begin
      chk(ev_total - ev0 == (wide ? 1 : 2), "R5 strobe count", ev_total - ev0, wide ? 1 : 2);
      chk(tail_bad == tb0 && !dq_en, "R5 data drive window", tail_bad - tb0, 0);
      chk(ev_c[ev0 % 4] - acc_cyc == F, "R5 float lead", ev_c[ev0 % 4] - acc_cyc, F);
      chk(ev_l[ev0 % 4] == R, "R5 strobe width", ev_l[ev0 % 4], R);
      chk(ev_a[ev0 % 4] == ha0, "R7 R6 write address", ev_a[ev0 % 4], ha0);
      if (wide) chk(ev_d[ev0 % 4] == wd, "R7 write data", ev_d[ev0 % 4], wd);
      else begin
        chk(ev_d[ev0 % 4][15:0] == wd[15:0], "R6 low half first", ev_d[ev0 % 4], wd[15:0]);
        chk(ev_a[(ev0 + 1) % 4] == ha1 && ev_d[(ev0 + 1) % 4][15:0] == wd[31:16],
            "R6 high half second", ev_d[(ev0 + 1) % 4], wd[31:16]);
        chk(ev_l[(ev0 + 1) % 4] == R, "R5 second strobe width", ev_l[(ev0 + 1) % 4], R);
      end
    end
    // R8 hold after the access
    repeat (2) @(negedge clk);
    chk(maddr == last_ha && oe_n == we, "R8 address/oe hold", {oe_n, maddr}, {we, last_ha});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && oe_n && we_n && !dq_en && !rsp_valid && maddr == '0, "R1 reset",
        {req_ready, oe_n, we_n, dq_en, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R10 ready idle", req_ready, 1);

    access(1'b0, 24'd5, '0, -1, 0);          // R4 first read random
    access(1'b0, 24'd6, '0, -1, 0);          // R3 same page
    access(1'b0, 24'd8, '0, -1, 0);          // R4 page change
    access(1'b1, 24'd9, 32'hCAFE_F00D, -1, 0);
    access(1'b0, 24'd9, '0, -1, 0);          // R4 after write
    @(negedge clk);
    hiz_n = 1'b0;
    @(negedge clk);
    chk(!req_ready && !ctl_en, "R9 idle float", {req_ready, ctl_en}, 0);
    hiz_n = 1'b1;
    cfg_f = 2'd0; cfg_r = 4'd0; cfg_p = 3'd0;
    access(1'b0, 24'd12, '0, -1, 0);         // minimum counts
    access(1'b0, 24'd13, '0, -1, 0);
    cfg_f = 2'd3; cfg_r = 4'd15; cfg_p = 3'd7;
    access(1'b0, 24'd13, '0, 3, 4);          // R9 stall mid-read
    cfg_wide = 1'b0;
    access(1'b0, 24'd20, '0, -1, 0);         // R6
    access(1'b1, 24'd21, 32'h1357_9BDF, -1, 0);
    access(1'b0, 24'd21, '0, 1, 2);

    void'($urandom(32'd1234));
    for (int i = 0; i < 240; i++) begin
      int sa, sl;
      bit we;
      if (i % 12 == 0) begin
        @(negedge clk);
        cfg_f = 2'($urandom); cfg_r = 4'($urandom); cfg_p = 3'($urandom);
        cfg_wide = 1'($urandom);
      end
      we = ($urandom % 4) == 0;
      sa = -1; sl = 0;
      if (!we && ($urandom % 6) == 0) begin sa = 0; sl = 1 + int'($urandom % 3); end
      access(we, 24'($urandom % 40), $urandom, sa, sl);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule